// File: doc/BRIEF.md
# Vector Accumulate Memory Engine

This engine adds one vector of 32-bit integers into a second vector in place, over two AXI4 master ports into global memory. The first port only reads the addend vector (called A here). The second port reads the accumulator vector (called B) and then writes the updated values back to the same addresses. A single-cycle start pulse captures two 64-bit byte base addresses and an element count. A single-cycle done pulse reports that the last write response has come back.

The work is cut into incrementing bursts of whole 512-bit beats. Every beat carries sixteen 32-bit lanes, and the lanes are added independently. Each burst runs in a fixed order. First the two read bursts are issued and their data is gathered into a sum buffer. Then one write burst is issued, and the engine waits for its response before it plans the next burst. Base addresses are expected to be 64-byte aligned, and the element count a multiple of sixteen.

Top module: `vacc_engine`

## Requirements
- R1: The job covers floor(count/16) beats. When that is zero, done is high in the cycle after the start pulse is taken, and no read or write address is issued on either port.
- R2: The first port only issues read addresses. For each burst, the second port reads a range and then writes the same address with the same length. A read address held without acceptance keeps its address and length stable.
- R3: Every burst uses burst code 2'b01 (incrementing) and size code 3'b110 (64 bytes per beat) on 64-bit addresses.
- R4: Every write beat drives all 64 write strobe bits high.
- R5: Each burst length is the smallest of: the beats remaining, 64, and the beats left before the next 4 KB boundary for A and for B. No burst crosses a 4 KB boundary.
- R6: The write address of a burst is issued only after the final beat of both read bursts. Write data follows only after that write address is accepted. No read data is accepted while write data is offered.
- R7: Element i sits in beat i/16, bits [32*(i%16) +: 32]. Each result lane is the A lane plus the B lane, modulo 2^32, with no carry into the neighbouring lane.
- R8: WLAST is high on the final beat of every write burst and on no other beat.
- R9: Done is a one-cycle pulse, high in the cycle after the final write response is accepted. A job gives exactly one done.
- R10: A start pulse that arrives while a job is running is ignored. Its arguments are never used.
- R11: Out of reset, done and every valid on both ports are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| baseA | input | 64 | Byte address of vector A |
| baseB | input | 64 | Byte address of vector B |
| elemCount | input | 32 | Number of 32-bit elements |
| done | output | 1 | Completion pulse |
| aArvalid | output | 1 | Port A read address valid |
| aArready | input | 1 | Port A read address ready |
| aAraddr | output | 64 | Port A read address |
| aArlen | output | 8 | Port A burst length minus one |
| aArsize | output | 3 | Port A beat size code |
| aArburst | output | 2 | Port A burst type |
| aRvalid | input | 1 | Port A read data valid |
| aRready | output | 1 | Port A read data ready |
| aRdata | input | 512 | Port A read data |
| aRlast | input | 1 | Port A final read beat |
| bArvalid | output | 1 | Port B read address valid |
| bArready | input | 1 | Port B read address ready |
| bAraddr | output | 64 | Port B read address |
| bArlen | output | 8 | Port B read length minus one |
| bArsize | output | 3 | Port B read size code |
| bArburst | output | 2 | Port B read burst type |
| bRvalid | input | 1 | Port B read data valid |
| bRready | output | 1 | Port B read data ready |
| bRdata | input | 512 | Port B read data |
| bRlast | input | 1 | Port B final read beat |
| bAwvalid | output | 1 | Port B write address valid |
| bAwready | input | 1 | Port B write address ready |
| bAwaddr | output | 64 | Port B write address |
| bAwlen | output | 8 | Port B write length minus one |
| bAwsize | output | 3 | Port B write size code |
| bAwburst | output | 2 | Port B write burst type |
| bWvalid | output | 1 | Port B write data valid |
| bWready | input | 1 | Port B write data ready |
| bWdata | output | 512 | Port B write data |
| bWstrb | output | 64 | Port B write strobes |
| bWlast | output | 1 | Port B final write beat |
| bBvalid | input | 1 | Port B write response valid |
| bBready | output | 1 | Port B write response ready |

## Verification
Sum correctness is first checked with one-beat and ten-beat jobs over hashed data. These separate lane placement and beat ordering errors from a plain adder fault. A filler of all-ones plus small B values exposes any carry that leaks between lanes. Two jobs are aimed at the burst splitter: one starts both vectors a few beats short of different 4 KB boundaries, and one runs 200 beats so the 64-beat cap applies. Random ready and valid stalls are switched on for some of the jobs. A start pulse is injected while a job is running to show that it is ignored. Counts of 0 and 15 show that no bus traffic is issued for an empty job.

// File: rtl/vacc_pkg.sv
package vacc_pkg;
  // Strobes the control issues to the datapath.
  typedef struct packed {
    logic burstStart;   // rewind capture and send pointers
    logic captureBeat;  // paired read beat accepted, store its sum
    logic sendBeat;     // write beat accepted, step to next stored sum
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_ADDR, ST_READ, ST_WADDR, ST_WDATA, ST_RESP
  } ctrlState_t;
endpackage

// File: rtl/vacc_burst_sizer.sv
module vacc_burst_sizer #(
  parameter int CNT_W      = 32,
  parameter int MAX_BEATS  = 64,
  parameter int PAGE_BEATS = 64,
  parameter int OFF_W      = 6,
  localparam int LEN_W     = $clog2(MAX_BEATS) + 1
) (
  input  logic [OFF_W-1:0] offA,      // beat index of A inside its page
  input  logic [OFF_W-1:0] offB,      // beat index of B inside its page
  input  logic [CNT_W-1:0] remBeats,
  output logic [LEN_W-1:0] burstLen
);
  always_comb begin
    int unsigned roomA, roomB, best;
    roomA = PAGE_BEATS - int'(offA);
    roomB = PAGE_BEATS - int'(offB);
    best  = MAX_BEATS;
    if (roomA < best) best = roomA;
    if (roomB < best) best = roomB;
    if (remBeats < CNT_W'(best)) best = 32'(remBeats);
    burstLen = LEN_W'(best);
  end
endmodule

// File: rtl/vacc_datapath.sv
module vacc_datapath import vacc_pkg::*; #(
  parameter int DATA_W    = 512,
  parameter int LANE_W    = 32,
  parameter int MAX_BEATS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] bData,
  output logic [DATA_W-1:0] wrData
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int IDX_W = $clog2(MAX_BEATS);

  logic [DATA_W-1:0] laneSum;
  logic [DATA_W-1:0] sumBuf [MAX_BEATS];
  logic [IDX_W-1:0]  capIdx, sendIdx;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneSum[g*LANE_W +: LANE_W] = aData[g*LANE_W +: LANE_W] + bData[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx  <= '0;
      sendIdx <= '0;
    end else if (strobe.burstStart) begin
      capIdx  <= '0;
      sendIdx <= '0;
    end else begin
      if (strobe.captureBeat) capIdx  <= capIdx + 1'b1;
      if (strobe.sendBeat)    sendIdx <= sendIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.captureBeat) sumBuf[capIdx] <= laneSum;
  end

  assign wrData = sumBuf[sendIdx];
endmodule

// File: rtl/vacc_ctrl.sv
module vacc_ctrl import vacc_pkg::*; #(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 32,
  parameter int MAX_BEATS  = 64,
  parameter int BEAT_BYTES = 64,
  parameter int LANES      = 16,
  localparam int LEN_W     = $clog2(MAX_BEATS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseA,
  input  logic [ADDR_W-1:0] baseB,
  input  logic [CNT_W-1:0]  elemCount,
  output logic              done,
  output logic [ADDR_W-1:0] addrA,
  output logic [ADDR_W-1:0] addrB,
  output logic [CNT_W-1:0]  remBeats,
  input  logic [LEN_W-1:0]  burstLen,
  output logic [LEN_W-1:0]  curLen,
  output logic              aArvalid,
  input  logic              aArready,
  output logic              bArvalid,
  input  logic              bArready,
  input  logic              aRvalid,
  input  logic              bRvalid,
  input  logic              aRlast,
  input  logic              bRlast,
  output logic              rReady,
  output logic              bAwvalid,
  input  logic              bAwready,
  output logic              bWvalid,
  input  logic              bWready,
  output logic              bWlast,
  input  logic              bBvalid,
  output logic              bBready,
  output dpStrobe_t         strobe
);
  localparam int LANE_LSB = $clog2(LANES);
  localparam int BEAT_LSB = $clog2(BEAT_BYTES);

  ctrlState_t state;
  logic [LEN_W-1:0] beatCnt;
  logic aAddrTaken, bAddrTaken;
  logic rdHs, wrHs, lastW;
  logic [CNT_W-1:0] jobBeats;
  logic [ADDR_W-1:0] step;

  assign jobBeats = CNT_W'(elemCount >> LANE_LSB);
  assign step     = ADDR_W'(curLen) << BEAT_LSB;

  assign aArvalid = (state == ST_ADDR) && !aAddrTaken;
  assign bArvalid = (state == ST_ADDR) && !bAddrTaken;
  assign rReady   = (state == ST_READ) && aRvalid && bRvalid;
  assign rdHs     = rReady;
  assign bAwvalid = (state == ST_WADDR);
  assign bWvalid  = (state == ST_WDATA);
  assign wrHs     = bWvalid && bWready;
  assign lastW    = (beatCnt == curLen - LEN_W'(1));
  assign bWlast   = bWvalid && lastW;
  assign bBready  = (state == ST_RESP);

  assign strobe.burstStart  = (state == ST_PLAN);
  assign strobe.captureBeat = rdHs;
  assign strobe.sendBeat    = wrHs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      addrA      <= '0;
      addrB      <= '0;
      remBeats   <= '0;
      curLen     <= '0;
      beatCnt    <= '0;
      aAddrTaken <= 1'b0;
      bAddrTaken <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          addrA    <= baseA;
          addrB    <= baseB;
          remBeats <= jobBeats;
          if (jobBeats == '0) done  <= 1'b1;
          else                state <= ST_PLAN;
        end
        ST_PLAN: begin
          curLen     <= burstLen;
          beatCnt    <= '0;
          aAddrTaken <= 1'b0;
          bAddrTaken <= 1'b0;
          state      <= ST_ADDR;
        end
        ST_ADDR: begin
          if (aArvalid && aArready) aAddrTaken <= 1'b1;
          if (bArvalid && bArready) bAddrTaken <= 1'b1;
          if ((aAddrTaken || aArready) && (bAddrTaken || bArready)) state <= ST_READ;
        end
        ST_READ: if (rdHs && (aRlast || bRlast)) state <= ST_WADDR;
        ST_WADDR: if (bAwready) state <= ST_WDATA;
        ST_WDATA: if (wrHs) begin
          beatCnt <= beatCnt + LEN_W'(1);
          if (lastW) state <= ST_RESP;
        end
        ST_RESP: if (bBvalid) begin
          addrA    <= addrA + step;
          addrB    <= addrB + step;
          remBeats <= remBeats - CNT_W'(curLen);
          if (remBeats == CNT_W'(curLen)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_PLAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vacc_engine.sv
module vacc_engine import vacc_pkg::*; #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 512,
  parameter int LANE_W     = 32,
  parameter int CNT_W      = 32,
  parameter int MAX_BEATS  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   baseA,
  input  logic [ADDR_W-1:0]   baseB,
  input  logic [CNT_W-1:0]    elemCount,
  output logic                done,
  output logic                aArvalid,
  input  logic                aArready,
  output logic [ADDR_W-1:0]   aAraddr,
  output logic [7:0]          aArlen,
  output logic [2:0]          aArsize,
  output logic [1:0]          aArburst,
  input  logic                aRvalid,
  output logic                aRready,
  input  logic [DATA_W-1:0]   aRdata,
  input  logic                aRlast,
  output logic                bArvalid,
  input  logic                bArready,
  output logic [ADDR_W-1:0]   bAraddr,
  output logic [7:0]          bArlen,
  output logic [2:0]          bArsize,
  output logic [1:0]          bArburst,
  input  logic                bRvalid,
  output logic                bRready,
  input  logic [DATA_W-1:0]   bRdata,
  input  logic                bRlast,
  output logic                bAwvalid,
  input  logic                bAwready,
  output logic [ADDR_W-1:0]   bAwaddr,
  output logic [7:0]          bAwlen,
  output logic [2:0]          bAwsize,
  output logic [1:0]          bAwburst,
  output logic                bWvalid,
  input  logic                bWready,
  output logic [DATA_W-1:0]   bWdata,
  output logic [DATA_W/8-1:0] bWstrb,
  output logic                bWlast,
  input  logic                bBvalid,
  output logic                bBready
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int LANES      = DATA_W / LANE_W;
  localparam int BEAT_LSB   = $clog2(BEAT_BYTES);
  localparam int PAGE_LSB   = $clog2(PAGE_BYTES);
  localparam int OFF_W      = PAGE_LSB - BEAT_LSB;
  localparam int LEN_W      = $clog2(MAX_BEATS) + 1;
  localparam logic [2:0] SIZE_CODE = 3'(BEAT_LSB);
  localparam logic [1:0] INCR_CODE = 2'b01;

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] addrA, addrB;
  logic [CNT_W-1:0]  remBeats;
  logic [LEN_W-1:0]  burstLen, curLen;
  logic              rReady;
  logic [7:0]        lenField;

  vacc_burst_sizer #(.CNT_W(CNT_W), .MAX_BEATS(MAX_BEATS),
                     .PAGE_BEATS(PAGE_BYTES / BEAT_BYTES), .OFF_W(OFF_W)) uSizer (
    .offA(addrA[PAGE_LSB-1:BEAT_LSB]), .offB(addrB[PAGE_LSB-1:BEAT_LSB]),
    .remBeats(remBeats), .burstLen(burstLen));

  vacc_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BEATS(MAX_BEATS),
              .BEAT_BYTES(BEAT_BYTES), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .baseA(baseA), .baseB(baseB),
    .elemCount(elemCount), .done(done), .addrA(addrA), .addrB(addrB),
    .remBeats(remBeats), .burstLen(burstLen), .curLen(curLen),
    .aArvalid(aArvalid), .aArready(aArready), .bArvalid(bArvalid), .bArready(bArready),
    .aRvalid(aRvalid), .bRvalid(bRvalid), .aRlast(aRlast), .bRlast(bRlast),
    .rReady(rReady), .bAwvalid(bAwvalid), .bAwready(bAwready),
    .bWvalid(bWvalid), .bWready(bWready), .bWlast(bWlast),
    .bBvalid(bBvalid), .bBready(bBready), .strobe(strobe));

  vacc_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .MAX_BEATS(MAX_BEATS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aData(aRdata), .bData(bRdata),
    .wrData(bWdata));

  assign lenField = 8'(curLen) - 8'd1;

  assign aAraddr  = addrA;
  assign aArlen   = lenField;
  assign aArsize  = SIZE_CODE;
  assign aArburst = INCR_CODE;
  assign aRready  = rReady;

  assign bAraddr  = addrB;
  assign bArlen   = lenField;
  assign bArsize  = SIZE_CODE;
  assign bArburst = INCR_CODE;
  assign bRready  = rReady;

  assign bAwaddr  = addrB;
  assign bAwlen   = lenField;
  assign bAwsize  = SIZE_CODE;
  assign bAwburst = INCR_CODE;
  assign bWstrb   = '1;
endmodule

// File: rtl/vacc_checker.sv
module vacc_checker #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              aArvalid,
  input logic              aArready,
  input logic [ADDR_W-1:0] aAraddr,
  input logic [7:0]        aArlen,
  input logic              aRready,
  input logic              bRready,
  input logic              bAwvalid,
  input logic              bAwready,
  input logic [11:0]       bAwaddrLo,
  input logic [7:0]        bAwlen,
  input logic              bWvalid,
  input logic              bWready,
  input logic              bWlast,
  input logic              bBvalid,
  input logic              bBready
);
  logic awOpen;  // write address accepted, its data not yet finished

  always_ff @(posedge clk) begin
    if (!rstN) awOpen <= 1'b0;
    else if (bAwvalid && bAwready) awOpen <= 1'b1;
    else if (bWvalid && bWready && bWlast) awOpen <= 1'b0;
  end

  AST_A_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    aArvalid && !aArready |=> aArvalid && $stable(aAraddr) && $stable(aArlen)); // R2

  AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    bAwvalid |-> (32'(bAwaddrLo) + (32'(bAwlen) + 32'd1) * 32'd64) <= 32'(PAGE_BYTES)); // R5

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    bWvalid |-> !aRready && !bRready); // R6

  AST_AW_BEFORE_W: assert property (@(posedge clk) disable iff (!rstN)
    bWvalid |-> awOpen); // R6

  AST_WLAST_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    bWvalid && bWready && bWlast |=> !bWvalid); // R8

  AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(bBvalid && bBready) || $past(start)); // R9
endmodule

bind vacc_engine vacc_checker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .aArvalid(aArvalid), .aArready(aArready), .aAraddr(aAraddr), .aArlen(aArlen),
  .aRready(aRready), .bRready(bRready), .bAwvalid(bAwvalid), .bAwready(bAwready),
  .bAwaddrLo(bAwaddr[11:0]), .bAwlen(bAwlen), .bWvalid(bWvalid), .bWready(bWready),
  .bWlast(bWlast), .bBvalid(bBvalid), .bBready(bBready));

// File: tb/sim_vacc_engine.sv
`timescale 1ns/1ps
module sim_vacc_engine;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [63:0] baseA = '0, baseB = '0;
  logic [31:0] elemCount = '0;
  logic done;
  logic aArvalid, aArready, aRvalid, aRready, aRlast;
  logic [63:0] aAraddr; logic [7:0] aArlen; logic [2:0] aArsize; logic [1:0] aArburst;
  logic [511:0] aRdata;
  logic bArvalid, bArready, bRvalid, bRready, bRlast;
  logic [63:0] bAraddr; logic [7:0] bArlen; logic [2:0] bArsize; logic [1:0] bArburst;
  logic [511:0] bRdata;
  logic bAwvalid, bAwready, bWvalid, bWready, bWlast, bBvalid, bBready;
  logic [63:0] bAwaddr; logic [7:0] bAwlen; logic [2:0] bAwsize; logic [1:0] bAwburst;
  logic [511:0] bWdata; logic [63:0] bWstrb;

  always #2.5 clk = ~clk;

  vacc_engine u0 (.*);

  int total = 0, bad = 0;
  logic [511:0] mem [512];
  logic [15:0] lfsr;
  bit stallOn = 0;

  int arA = 0, arB = 0, awN = 0, pageBad = 0, lenBad = 0, kindBad = 0;
  int strbBad = 0, lastBad = 0, orderBad = 0, addrBad = 0, maxLen = 0;

  function automatic int ix(input logic [63:0] a);
    return int'(a[14:6]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) lfsr <= 16'hACE1;
    else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // Port A read slave
  logic aBusy, aGate; logic [63:0] aPtr; logic [8:0] aLeft;
  assign aRvalid = aBusy && aGate;
  assign aRdata  = mem[ix(aPtr)];
  assign aRlast  = aLeft == 9'd1;
  always @(posedge clk) begin
    if (!rstN) begin aBusy <= 0; aArready <= 0; aGate <= 0; aLeft <= 0; aPtr <= 0; end
    else begin
      aGate <= !stallOn || lfsr[3] || (aRvalid && !aRready);
      if (!aBusy) aArready <= 1;
      if (aArvalid && aArready) begin
        aArready <= 0; aBusy <= 1; aPtr <= aAraddr; aLeft <= 9'(aArlen) + 9'd1;
      end
      if (aRvalid && aRready) begin
        aPtr <= aPtr + 64; aLeft <= aLeft - 9'd1;
        if (aLeft == 9'd1) aBusy <= 0;
      end
    end
  end

  // Port B read slave
  logic rBusy, rGate; logic [63:0] rPtr; logic [8:0] rLeft; logic [63:0] lastBAr;
  assign bRvalid = rBusy && rGate;
  assign bRdata  = mem[ix(rPtr)];
  assign bRlast  = rLeft == 9'd1;
  always @(posedge clk) begin
    if (!rstN) begin rBusy <= 0; bArready <= 0; rGate <= 0; rLeft <= 0; rPtr <= 0; lastBAr <= 0; end
    else begin
      rGate <= !stallOn || lfsr[7] || (bRvalid && !bRready);
      if (!rBusy) bArready <= 1;
      if (bArvalid && bArready) begin
        bArready <= 0; rBusy <= 1; rPtr <= bAraddr; lastBAr <= bAraddr;
        rLeft <= 9'(bArlen) + 9'd1;
      end
      if (bRvalid && bRready) begin
        rPtr <= rPtr + 64; rLeft <= rLeft - 9'd1;
        if (rLeft == 9'd1) rBusy <= 0;
      end
    end
  end

  // Port B write slave and protocol monitor
  logic wBusy, wGate; logic [63:0] wPtr; logic [8:0] wLeft;
  assign bWready = wBusy && (wLeft != 0) && wGate;
  always @(posedge clk) begin
    if (!rstN) begin wBusy <= 0; bAwready <= 0; bBvalid <= 0; wGate <= 0; wLeft <= 0; wPtr <= 0; end
    else begin
      wGate <= !stallOn || lfsr[11];
      if (!wBusy) bAwready <= 1;
      if (bAwvalid && bAwready) begin
        bAwready <= 0; wBusy <= 1; wPtr <= bAwaddr; wLeft <= 9'(bAwlen) + 9'd1;
      end
      if (bWvalid && bWready) begin
        mem[ix(wPtr)] <= bWdata;
        wPtr <= wPtr + 64; wLeft <= wLeft - 9'd1;
        if (wLeft == 9'd1) bBvalid <= 1;
      end
      if (bBvalid && bBready) begin bBvalid <= 0; wBusy <= 0; end
    end
  end

  always @(posedge clk) if (rstN) begin
    if (aArvalid && aArready) begin
      arA++;
      if (aArburst != 2'b01 || aArsize != 3'b110) kindBad++;
      if (32'(aAraddr[11:0]) + (32'(aArlen) + 1) * 64 > 4096) pageBad++;
    end
    if (bArvalid && bArready) begin
      arB++;
      if (bArburst != 2'b01 || bArsize != 3'b110) kindBad++;
      if (32'(bAraddr[11:0]) + (32'(bArlen) + 1) * 64 > 4096) pageBad++;
    end
    if (bAwvalid && bAwready) begin
      awN++;
      if (bAwburst != 2'b01 || bAwsize != 3'b110) kindBad++;
      if (32'(bAwaddr[11:0]) + (32'(bAwlen) + 1) * 64 > 4096) pageBad++;
      if (bAwlen > 8'd63) lenBad++;
      if (32'(bAwlen) + 1 > maxLen) maxLen = 32'(bAwlen) + 1;
      if (aBusy || rBusy) orderBad++;
      if (bAwaddr != lastBAr) addrBad++;
    end
    if (bWvalid && !wBusy) orderBad++;
    if (bWvalid && bWready) begin
      if (bWstrb != '1) strbBad++;
      if (bWlast != (wLeft == 9'd1)) lastBad++;
    end
  end

  function automatic logic [31:0] hashVal(input int seed, input int i);
    return 32'(seed) * 32'h9E3779B9 ^ 32'(i) * 32'h01000193 ^ 32'h5A5A0000;
  endfunction

  task automatic fillRegion(input logic [63:0] base, input int beats, input int seed, input int mode);
    for (int j = 0; j < beats; j++) begin
      logic [511:0] v;
      for (int l = 0; l < 16; l++) begin
        if (mode == 1) v[l*32 +: 32] = (seed == 0) ? 32'hFFFF_FFFF : 32'(l + 1);
        else v[l*32 +: 32] = hashVal(seed, j * 16 + l);
      end
      mem[ix(base) + j] = v;
    end
  endtask

  int expBursts;
  task automatic planBursts(input logic [63:0] a, input logic [63:0] b, input int beats);
    int rem = beats, pa = int'(a[11:6]), pb = int'(b[11:6]);
    expBursts = 0;
    while (rem > 0) begin
      int len = rem;
      if (len > 64) len = 64;
      if (64 - pa < len) len = 64 - pa;
      if (64 - pb < len) len = 64 - pb;
      pa = (pa + len) % 64; pb = (pb + len) % 64;
      rem -= len; expBursts++;
    end
  endtask

  task automatic runJob(input logic [63:0] a, input logic [63:0] b, input int cnt,
                        input bit inject, input string tag);
    int beats = cnt / 16;
    logic [511:0] expB [256];
    logic [511:0] gLo, gHi, gX0, gX1;
    int dones = 0, firstDone = 0, wrong = 0, firstBad = -1;
    for (int j = 0; j < beats; j++)
      for (int l = 0; l < 16; l++)
        expB[j][l*32 +: 32] = mem[ix(a) + j][l*32 +: 32] + mem[ix(b) + j][l*32 +: 32];
    gLo = mem[ix(b) - 1]; gHi = mem[ix(b) + beats];
    gX0 = mem[ix(64'h7000)]; gX1 = mem[ix(64'h7000) + 1];
    planBursts(a, b, beats);
    @(negedge clk);
    arA = 0; arB = 0; awN = 0; pageBad = 0; lenBad = 0; kindBad = 0;
    strbBad = 0; lastBad = 0; orderBad = 0; addrBad = 0; maxLen = 0;
    baseA = a; baseB = b; elemCount = 32'(cnt); start = 1;
    for (int cyc = 1; cyc < 6000; cyc++) begin
      @(negedge clk);
      start = 0;
      if (inject && cyc == 10) begin baseA = 64'h6000; baseB = 64'h7000; elemCount = 32; start = 1; end
      if (done) begin dones++; if (firstDone == 0) firstDone = cyc; end
      if (firstDone != 0 && cyc > firstDone + 6) break;
    end
    check(dones == 1, {"R9 one done per job ", tag}, 64'(dones), 64'd1);
    if (beats == 0) begin
      check(firstDone == 1, {"R1 empty job done latency ", tag}, 64'(firstDone), 64'd1);
      check(arA + arB + awN == 0, {"R1 empty job bus traffic ", tag}, 64'(arA + arB + awN), 64'd0);
    end else begin
      for (int j = 0; j < beats; j++)
        if (mem[ix(b) + j] != expB[j]) begin wrong++; if (firstBad < 0) firstBad = j; end
      check(wrong == 0, {"R7 lane sums ", tag}, 64'(wrong), 64'd0);
      if (firstBad >= 0)
        check(0, {"R7 first bad beat lane0 ", tag}, 64'(mem[ix(b) + firstBad][31:0]), 64'(expB[firstBad][31:0]));
      check(mem[ix(b) - 1] == gLo && mem[ix(b) + beats] == gHi, {"R2 writes stay in range ", tag}, 64'(0), 64'(0));
      check(awN == expBursts && arA == expBursts && arB == expBursts,
            {"R5 burst count ", tag}, 64'(awN), 64'(expBursts));
      check(pageBad == 0 && lenBad == 0, {"R5 page and length limit ", tag}, 64'(pageBad + lenBad), 64'd0);
      check(kindBad == 0, {"R3 burst and size code ", tag}, 64'(kindBad), 64'd0);
      check(strbBad == 0, {"R4 full strobes ", tag}, 64'(strbBad), 64'd0);
      check(lastBad == 0, {"R8 wlast placement ", tag}, 64'(lastBad), 64'd0);
      check(orderBad == 0, {"R6 read before write ", tag}, 64'(orderBad), 64'd0);
      check(addrBad == 0, {"R2 write address equals read address ", tag}, 64'(addrBad), 64'd0);
    end
    if (inject)
      check(mem[ix(64'h7000)] == gX0 && mem[ix(64'h7000) + 1] == gX1,
            "R10 start while busy ignored", 64'(0), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = {16{32'(i) * 32'h0101_0101}};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(done == 0 && !aArvalid && !bArvalid && !bAwvalid && !bWvalid,
          "R11 outputs idle in reset", {59'd0, done, aArvalid, bArvalid, bAwvalid, bWvalid}, 64'd0);
    rstN = 1;
    @(negedge clk);
    check(done == 0 && !aArvalid && !bArvalid && !bAwvalid && !bWvalid,
          "R11 outputs idle after reset", {59'd0, done, aArvalid, bArvalid, bAwvalid, bWvalid}, 64'd0);

    runJob(64'h0000, 64'h4000, 0, 0, "count0");
    runJob(64'h0000, 64'h4000, 15, 0, "count15");

    fillRegion(64'h0000, 1, 3, 0); fillRegion(64'h4000, 1, 4, 0);
    runJob(64'h0000, 64'h4000, 16, 0, "one beat");

    stallOn = 1;
    fillRegion(64'h0400, 10, 5, 0); fillRegion(64'h4400, 10, 6, 0);
    runJob(64'h0400, 64'h4400, 160, 1, "ten beats stalled");

    fillRegion(64'h0F80, 8, 7, 0); fillRegion(64'h2EC0, 8, 8, 0);
    runJob(64'h0F80, 64'h2EC0, 128, 0, "page crossing");
    check(expBursts == 3, "R5 page split expected three bursts", 64'(awN), 64'd3);

    stallOn = 0;
    fillRegion(64'h0000, 200, 9, 0); fillRegion(64'h4000, 200, 10, 0);
    runJob(64'h0000, 64'h4000, 3200, 0, "long");
    check(maxLen == 64, "R5 longest burst capped at 64", 64'(maxLen), 64'd64);

    fillRegion(64'h0800, 2, 0, 1); fillRegion(64'h5000, 2, 1, 1);
    runJob(64'h0800, 64'h5000, 32, 0, "lane wrap");
    check(mem[ix(64'h5000)][31:0] == 32'h0 && mem[ix(64'h5000)][63:32] == 32'h1,
          "R7 lane wrap without carry", 64'(mem[ix(64'h5000)][63:0]), 64'h0000_0001_0000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule